// File: doc/BRIEF.md
# SPI Burst Master with Refillable Transmit Queue

This block is an SPI master (mode 0, most significant bit first) fed by a queue of 32-bit transmit words. Software programs a burst length in bits and sets a start bit, called the exchange bit here. A 0-to-1 change of that bit starts shifting. Words are moved one at a time from the transmit queue into a shift register and sent on MOSI. One MISO bit is captured for every MOSI bit, and each word's received bits go into a receive queue.

A burst may be longer than the transmit queue can hold. When the queue and the shift register run dry, hardware clears the exchange bit and raises the done flag. Chip select stays low and the remaining bit count is kept. Software then refills the queue and writes the exchange bit from 0 to 1, and shifting resumes where it stopped. If the burst count runs out while words are still queued, the exchange bit stays set. Chip select then goes high for one cycle and a new burst of the programmed length starts.

Register map on `bus_addr`:
- Address 0: a write pushes a transmit word; a read pops a receive word.
- Address 1: control. Bit 0 is the exchange bit. Bits 16 and up hold the burst length minus one.
- Address 2: status. Bit 0 is the done flag (write 1 to clear). Bit 1 means receive data is waiting. Bit 2 means chip select is active.

Top module: `spi_burst_master`

## Requirements
- R1: MOSI carries each word most significant bit first. SCLK idles low. MISO is sampled when SCLK rises, and MOSI only changes while SCLK is low.
- R2: Control bits [16 +: LEN_W] hold the burst length minus one. A burst sends exactly that many bits. When fewer than 32 bits remain, the word popped next sends only its low-order remaining bits.
- R3: `cs_n` is low from the start of a burst until its last bit has been shifted, including any pause for refill. It is high afterwards, and SCLK only pulses while `cs_n` is low.
- R4: When the transmit queue and the shift register are both empty, the exchange bit (control bit 0) clears itself, even if bits of the burst remain, and status bit 0 is set.
- R5: The end of a burst with words still queued does not clear the exchange bit. Chip select goes high for one cycle and the next burst starts with the stored length.
- R6: Only a 0-to-1 write of the exchange bit starts or resumes shifting. A resume keeps the remaining count and ignores the length field. Writing 1 while the bit is already 1 has no effect.
- R7: Status bit 0 is set at the end of every burst and cleared by writing 1 to status bit 0.
- R8: At the end of each word, the bits received during that word are pushed into the receive queue right-aligned, first bit highest. Reading address 0 pops it, and status bit 1 shows whether data is waiting.
- R9: After reset `cs_n` is 1, SCLK is 0, the control and status registers read 0 and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at address 0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with a four-word transmit queue, a sixteen-word receive queue, a 12-bit length field and a divider of two. Because the transmit queue is only four words deep, bursts of a few hundred bits have to pause and resume several times. This exercises the self-clearing exchange bit, chip select held through a pause, and resumes that must ignore the length field. Bursts are random in length and refill size, so final partial words of every size occur. Directed cases cover a single short word, a burst that ends with words still queued, and a redundant start write during shifting.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 64,
  parameter int LEN_W    = 12,
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int TXA   = $clog2(TX_DEPTH);
  localparam int RXA   = $clog2(RX_DEPTH);
  localparam int REM_W = LEN_W + 1;
  localparam int DW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [31:0]      tx_mem [TX_DEPTH];
  logic [TXA-1:0]   tx_rp, tx_wp;
  logic [TXA:0]     tx_cnt;
  logic [31:0]      rx_mem [RX_DEPTH];
  logic [RXA-1:0]   rx_rp, rx_wp;
  logic [RXA:0]     rx_cnt;

  logic             xch, tc;
  logic [LEN_W-1:0] len_m1;
  logic [REM_W-1:0] remaining;
  logic [31:0]      sr, rx_sr;
  logic [5:0]       bit_cnt;
  logic [DW-1:0]    div;

  wire ctrl_wr   = bus_wr && bus_addr == 2'd1;
  wire stat_wr   = bus_wr && bus_addr == 2'd2;
  wire xch_rise  = ctrl_wr && bus_wdata[0] && !xch;
  wire idle_sr   = bit_cnt == 6'd0;
  wire tx_empty  = tx_cnt == '0;
  wire tx_push   = bus_wr && bus_addr == 2'd0 && tx_cnt != (TXA+1)'(TX_DEPTH);
  wire tx_pop    = xch && idle_sr && remaining != '0 && !tx_empty;
  wire new_burst = xch && idle_sr && remaining == '0 && !tx_empty;
  wire run_dry   = xch && idle_sr && tx_empty;
  wire tick      = div == DW'(HALF_DIV - 1);
  wire last_fall = !idle_sr && tick && sclk && bit_cnt == 6'd1;
  wire rx_push   = last_fall && rx_cnt != (RXA+1)'(RX_DEPTH);
  wire rx_pop    = bus_rd && bus_addr == 2'd0 && rx_cnt != '0;
  wire [5:0] take = (remaining >= REM_W'(32)) ? 6'd32 : remaining[5:0];

  assign mosi = sr[31];
  assign cs_n = !(remaining != '0 || !idle_sr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) begin
        tx_mem[tx_wp] <= bus_wdata;
        tx_wp <= (tx_wp == TXA'(TX_DEPTH - 1)) ? '0 : tx_wp + 1'b1;
      end
      if (tx_pop) tx_rp <= (tx_rp == TXA'(TX_DEPTH - 1)) ? '0 : tx_rp + 1'b1;
      if (tx_push && !tx_pop) tx_cnt <= tx_cnt + 1'b1;
      else if (!tx_push && tx_pop) tx_cnt <= tx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) begin
        rx_mem[rx_wp] <= rx_sr;
        rx_wp <= (rx_wp == RXA'(RX_DEPTH - 1)) ? '0 : rx_wp + 1'b1;
      end
      if (rx_pop) rx_rp <= (rx_rp == RXA'(RX_DEPTH - 1)) ? '0 : rx_rp + 1'b1;
      if (rx_push && !rx_pop) rx_cnt <= rx_cnt + 1'b1;
      else if (!rx_push && rx_pop) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xch <= 1'b0; tc <= 1'b0; len_m1 <= '0; remaining <= '0;
      sr <= '0; rx_sr <= '0; bit_cnt <= '0; div <= '0; sclk <= 1'b0;
    end else begin
      if (stat_wr && bus_wdata[0]) tc <= 1'b0;
      if (ctrl_wr) begin
        len_m1 <= bus_wdata[16 +: LEN_W];
        xch    <= bus_wdata[0];
      end
      if (xch_rise && remaining == '0 && idle_sr)
        remaining <= {1'b0, bus_wdata[16 +: LEN_W]} + REM_W'(1);
      if (run_dry) begin
        xch <= 1'b0;
        tc  <= 1'b1;
      end
      if (new_burst) remaining <= {1'b0, len_m1} + REM_W'(1);
      if (tx_pop) begin
        sr        <= tx_mem[tx_rp] << (6'd32 - take);
        bit_cnt   <= take;
        remaining <= remaining - REM_W'(take);
        div       <= '0;
        sclk      <= 1'b0;
        rx_sr     <= '0;
      end else if (!idle_sr) begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) begin
          if (!sclk) begin
            sclk  <= 1'b1;
            rx_sr <= {rx_sr[30:0], miso};
          end else begin
            sclk    <= 1'b0;
            sr      <= sr << 1;
            bit_cnt <= bit_cnt - 1'b1;
            if (bit_cnt == 6'd1 && remaining == '0) tc <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : 32'd0;
      2'd1:    bus_rdata = (32'(len_m1) << 16) | 32'(xch);
      2'd2:    bus_rdata = {29'd0, !cs_n, rx_cnt != '0, tc};
      default: bus_rdata = 32'd0;
    endcase
  end

  assert_mosi_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_sclk_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  assert_selfclear_dry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(xch) && !$past(ctrl_wr)) |-> ($past(tx_cnt) == '0 && $past(bit_cnt) == 6'd0));

  assert_resume_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xch_rise) && $past(remaining) != '0) |-> remaining == $past(remaining));

  assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> ($past(bit_cnt) == 6'd1 || $past(tx_cnt) == '0));

  always_ff @(posedge clk) begin
    if (rst_n) assert_word_size_R2: assert (bit_cnt <= 6'd32);
  end
endmodule

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic sclk, mosi, miso, cs_n;

  int total = 0, bad = 0;
  int cap_n = 0, cs_rises = 0;
  bit cap [8192];
  logic [31:0] words [16];

  spi_burst_master #(.TX_DEPTH(4), .RX_DEPTH(16), .LEN_W(12), .HALF_DIV(2)) u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit mbit(int i);
    return bit'((((i * 5) + (i >> 2)) % 3) == 0);
  endfunction

  assign miso = mbit(cap_n);

  always @(posedge sclk) begin
    if (!cs_n && cap_n < 8192) cap[cap_n] = mosi;
    cap_n++;
  end

  always @(posedge cs_n) cs_rises++;

  function automatic int wbits(int L, int w);
    int nw = (L + 31) / 32;
    return (w == nw - 1) ? L - 32 * (nw - 1) : 32;
  endfunction

  function automatic bit exp_tx(int L, int k);
    int w = k / 32;
    int n = wbits(L, w);
    return words[w][n - 1 - (k - 32 * w)];
  endfunction

  function automatic logic [31:0] exp_rx(int L, int base, int w);
    logic [31:0] v = 32'd0;
    for (int i = 0; i < wbits(L, w); i++) v = {v[30:0], mbit(base + 32 * w + i)};
    return v;
  endfunction

  function automatic logic [31:0] ctl(int lm1);
    return (32'(lm1) << 16) | 32'd1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_xch_low();
    logic [31:0] v;
    do rd(2'd1, v); while (v[0]);
  endtask

  task automatic check_bits(string req, int L, int base);
    int errs = 0;
    for (int k = 0; k < L; k++)
      if (base + k < 8192 && cap[base + k] !== exp_tx(L, k)) errs++;
    chk(req, errs, 0);
  endtask

  task automatic check_rx(int L, int base);
    logic [31:0] v;
    for (int w = 0; w < (L + 31) / 32; w++) begin
      rd(2'd0, v);
      chk("R8 rx word", v, exp_rx(L, base, w));
    end
    rd(2'd2, v);
    chk("R8 rx drained", 32'(v[1]), 32'd0);
  endtask

  task automatic run_burst(int L, int chunk, bit poke);
    int nw = (L + 31) / 32;
    int base = cap_n;
    int pushed = 0;
    bit first = 1'b1;
    logic [31:0] v;
    for (int w = 0; w < nw; w++) words[w] = $urandom;
    while (pushed < nw) begin
      for (int c = 0; c < chunk && pushed < nw; c++) begin
        wr(2'd0, words[pushed]);
        pushed++;
      end
      wr(2'd1, first ? ctl(L - 1) : ctl(5));
      if (poke && first) begin
        repeat (20) @(negedge clk);
        wr(2'd1, ctl(L - 1));
        rd(2'd1, v);
        chk("R6 redundant start keeps xch", 32'(v[0]), 32'd1);
      end
      first = 1'b0;
      wait_xch_low();
      if (pushed < nw) begin
        chk("R3 cs held in pause", 32'(cs_n), 32'd0);
        rd(2'd2, v);
        chk("R4 done on dry queue", 32'(v[0]), 32'd1);
        chk("R4 bits at pause", cap_n - base, 32 * pushed);
        wr(2'd2, 32'd1);
        rd(2'd2, v);
        chk("R7 w1c clears", 32'(v[0]), 32'd0);
      end
    end
    repeat (2) @(negedge clk);
    chk("R2 burst bit count", cap_n - base, L);
    check_bits("R1 R2 mosi bits", L, base);
    chk("R3 cs released", 32'(cs_n), 32'd1);
    rd(2'd2, v);
    chk("R7 done at end", 32'(v[0]), 32'd1);
    wr(2'd2, 32'd1);
    rd(2'd2, v);
    chk("R7 w1c clears", 32'(v[0]), 32'd0);
    check_rx(L, base);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, rises0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 cs_n reset", 32'(cs_n), 32'd1);
    chk("R9 sclk reset", 32'(sclk), 32'd0);
    rd(2'd1, v); chk("R9 ctrl reset", v, 32'd0);
    rd(2'd2, v); chk("R9 status reset", v, 32'd0);

    run_burst(64, 4, 1'b0);
    run_burst(200, 4, 1'b1);
    run_burst(5, 1, 1'b0);

    base = cap_n; rises0 = cs_rises;
    for (int w = 0; w < 3; w++) begin
      words[w] = $urandom;
      wr(2'd0, words[w]);
    end
    wr(2'd1, ctl(31));
    wait_xch_low();
    repeat (2) @(negedge clk);
    chk("R5 bursts chained", cs_rises - rises0, 3);
    chk("R5 chained bits", cap_n - base, 96);
    check_bits("R5 chained data", 96, base);
    wr(2'd2, 32'd1);
    check_rx(96, base);

    for (int t = 0; t < 6; t++)
      run_burst(int'($urandom_range(480, 1)), int'($urandom_range(4, 1)), 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule